// File: doc/BRIEF.md
# Conditional Trap Compare Unit

This unit decides whether a conditional trap instruction fires. It compares two operands at once in three ways: as signed values, as unsigned values and for equality. It packs the five results into a fixed-order flag vector and matches that vector against a condition mask taken from the instruction word. A narrow mode limits the comparison to the low half of each operand. The signed view is sign-extended from the low half, and the unsigned and equality views are zero-extended from it.

An exception-type vector from earlier stages forces the trap whether or not the compare matches. The unit is purely combinational. A pipeline stage places it between operand read and the stage that updates machine state, and the stage registers the unit's outputs itself.

Top module: `trap_cond_unit`

## Requirements
- R1: With `narrow_mode`=1, the signed flags compare bits 31:0 of each operand as sign-extended 64-bit values.
- R2: With `narrow_mode`=1, the unsigned and equality flags compare bits 31:0 of each operand as zero-extended values. Bits 63:32 have no effect on any flag.
- R3: With `narrow_mode`=0, every flag compares the full 64-bit operands.
- R4: `cmp_flags` bit 0 is unsigned a>b, bit 1 is unsigned a<b, bit 2 is a==b, bit 3 is signed a>b and bit 4 is signed a<b.
- R5: The condition mask is `insn_word[25:21]`, with mask bit k matching `cmp_flags` bit k. `trap_fire` is 1 when (flags AND mask) is nonzero.
- R6: `trap_fire` is 1 whenever any bit of `exc_pending` is 1, whatever the operands and mask.
- R7: With a zero mask and a zero `exc_pending`, `trap_fire` is 0.
- R8: With a mask of 5'b11111, `trap_fire` is 1 for every operand pair.
- R9: Exactly one of signed less, signed greater and equal is set, and exactly one of unsigned less, unsigned greater and equal is set.
- R10: Bits of `insn_word` outside 25:21 have no effect on either output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| insn_word | input | 32 | Instruction word carrying the condition mask field |
| opnd_a | input | 64 | First compare operand |
| opnd_b | input | 64 | Second compare operand |
| narrow_mode | input | 1 | 1 selects the low-half (32-bit) comparison |
| exc_pending | input | 8 | Pending exception types; any set bit forces the trap |
| cmp_flags | output | 5 | Comparison results in the order of R4 |
| trap_fire | output | 1 | Trap decision |

## Verification
The mask match and the exception override can both call for the trap on the same vector. The bench drives vectors where both causes are present, where only one is present and where neither is present. A behavioural model computes each cause separately from integer compares and ORs them, and the bench compares the result with `trap_fire` on every clock. The narrow-mode vectors put different upper halves beside equal or sign-critical low halves, so a signed-versus-unsigned extension mix-up shows up as a flag mismatch in the same cycle that a forced trap would otherwise hide it.

// File: rtl/trap_cmp_pkg.sv
// Shared sizes and the flag layout for the conditional trap compare unit.
// Assumes the flag order is fixed: a neighbour decodes it by bit position.
package trap_cmp_pkg;
    localparam int DATA_W  = 64;
    localparam int HALF_W  = DATA_W / 2;
    localparam int INSN_W  = 32;
    localparam int NCOND   = 5;
    localparam int COND_LSB = 21;
    localparam int EXC_W   = 8;

    // Packed MSB first, so s_lt is bit 4 and u_gt is bit 0.
    typedef struct packed {
        logic s_lt;
        logic s_gt;
        logic eq;
        logic u_lt;
        logic u_gt;
    } cmp_flags_t;
endpackage

// File: rtl/trap_operand_ext.sv
// Builds the signed and unsigned views of one operand.
// Assumes DATA_W is twice HALF_W; narrow mode uses only the low half.
module trap_operand_ext #(
    parameter int DATA_W = 64,
    parameter int HALF_W = 32
) (
    input  logic [DATA_W-1:0] raw,
    input  logic              narrow,
    output logic [DATA_W-1:0] sgn_view,
    output logic [DATA_W-1:0] uns_view
);
    localparam int UPPER_W = DATA_W - HALF_W;

    // Select the extension for each view from the mode flag.
    always_comb begin
        if (narrow) begin
            sgn_view = {{UPPER_W{raw[HALF_W-1]}}, raw[HALF_W-1:0]};
            uns_view = {{UPPER_W{1'b0}}, raw[HALF_W-1:0]};
        end else begin
            sgn_view = raw;
            uns_view = raw;
        end
    end

    // The two views share their low half in both modes.
    always_comb begin
        a_r2_low_half_shared: assert (sgn_view[HALF_W-1:0] == uns_view[HALF_W-1:0])
            else $error("views disagree in low half");
    end
endmodule

// File: rtl/trap_comparator.sv
// Produces the five ordered compare flags from prepared operand views.
// Assumes the views are already extended for the current mode.
module trap_comparator #(
    parameter int DATA_W = 64
) (
    input  logic [DATA_W-1:0]       sa,
    input  logic [DATA_W-1:0]       sb,
    input  logic [DATA_W-1:0]       ua,
    input  logic [DATA_W-1:0]       ub,
    output trap_cmp_pkg::cmp_flags_t flags
);
    // Evaluate signed, unsigned and equality relations in parallel.
    always_comb begin
        flags.s_lt = $signed(sa) < $signed(sb);
        flags.s_gt = $signed(sa) > $signed(sb);
        flags.eq   = ua == ub;
        flags.u_lt = ua < ub;
        flags.u_gt = ua > ub;
    end

    // Trichotomy must hold in both views.
    always_comb begin
        a_r9_signed_trichotomy: assert ($onehot({flags.s_lt, flags.s_gt, flags.eq}))
            else $error("signed relations not exclusive");
        a_r9_unsigned_trichotomy: assert ($onehot({flags.u_lt, flags.u_gt, flags.eq}))
            else $error("unsigned relations not exclusive");
    end
endmodule

// File: rtl/trap_mask_match.sv
// Matches the flag vector against the instruction mask and folds in the
// exception override. Assumes mask bit k selects flag bit k.
module trap_mask_match #(
    parameter int NCOND = 5,
    parameter int EXC_W = 8
) (
    input  logic [NCOND-1:0] flag_vec,
    input  logic [NCOND-1:0] cond_mask,
    input  logic [EXC_W-1:0] exc_vec,
    output logic             fire
);
    logic [NCOND-1:0] hit;

    // Per-condition enable, one gate per flag.
    for (genvar k = 0; k < NCOND; k++) begin : g_hit
        assign hit[k] = flag_vec[k] & cond_mask[k];
    end

    // Trap decision: any enabled hit or any pending exception.
    always_comb begin
        fire = (|hit) | (|exc_vec);
    end

    always_comb begin
        a_r6_exc_forces: assert (!(|exc_vec) || fire)
            else $error("pending exception did not fire");
        a_r7_quiet_when_idle: assert ((|cond_mask) || (|exc_vec) || !fire)
            else $error("fired with zero mask and no exception");
    end
endmodule

// File: rtl/trap_cond_unit.sv
// Top of the conditional trap compare unit: extends operands, compares,
// and matches the mask field of the instruction. Purely combinational.
module trap_cond_unit #(
    parameter int DATA_W   = trap_cmp_pkg::DATA_W,
    parameter int INSN_W   = trap_cmp_pkg::INSN_W,
    parameter int COND_LSB = trap_cmp_pkg::COND_LSB,
    parameter int EXC_W    = trap_cmp_pkg::EXC_W
) (
    input  logic [INSN_W-1:0] insn_word,
    input  logic [DATA_W-1:0] opnd_a,
    input  logic [DATA_W-1:0] opnd_b,
    input  logic              narrow_mode,
    input  logic [EXC_W-1:0]  exc_pending,
    output logic [4:0]        cmp_flags,
    output logic              trap_fire
);
    localparam int HALF_W = DATA_W / 2;
    localparam int NCOND  = trap_cmp_pkg::NCOND;
    localparam logic [INSN_W-1:0] FIELD_SEL = {{(INSN_W-NCOND){1'b0}}, {NCOND{1'b1}}} << COND_LSB;

    logic [DATA_W-1:0] sgn_v [2];
    logic [DATA_W-1:0] uns_v [2];
    logic [DATA_W-1:0] raw_v [2];
    logic [NCOND-1:0]  cond_mask;
    logic              unused_insn_bits;
    trap_cmp_pkg::cmp_flags_t flags;

    assign raw_v[0] = opnd_a;
    assign raw_v[1] = opnd_b;

    // One extender per operand.
    for (genvar i = 0; i < 2; i++) begin : g_ext
        trap_operand_ext #(.DATA_W(DATA_W), .HALF_W(HALF_W)) u_ext (
            .raw      (raw_v[i]),
            .narrow   (narrow_mode),
            .sgn_view (sgn_v[i]),
            .uns_view (uns_v[i])
        );
    end

    trap_comparator #(.DATA_W(DATA_W)) u_cmp (
        .sa    (sgn_v[0]),
        .sb    (sgn_v[1]),
        .ua    (uns_v[0]),
        .ub    (uns_v[1]),
        .flags (flags)
    );

    // Condition mask field extraction.
    assign cond_mask        = insn_word[COND_LSB +: NCOND];
    assign unused_insn_bits = ^(insn_word & ~FIELD_SEL);

    trap_mask_match #(.NCOND(NCOND), .EXC_W(EXC_W)) u_match (
        .flag_vec  (flags),
        .cond_mask (cond_mask),
        .exc_vec   (exc_pending),
        .fire      (trap_fire)
    );

    assign cmp_flags = flags;

    // Port-level relations between the compare result and the decision.
    always_comb begin
        a_r8_full_mask_fires: assert (!(&cond_mask) || trap_fire)
            else $error("full mask did not fire");
        a_r5_fire_has_cause: assert (!trap_fire || (|exc_pending) || (|(cmp_flags & cond_mask)))
            else $error("fire without cause");
        a_r2_narrow_equal_low: assert (!(narrow_mode && opnd_a[HALF_W-1:0] == opnd_b[HALF_W-1:0]) || cmp_flags[2])
            else $error("narrow equality missed");
    end
endmodule

// File: tb/trap_cond_unit_tb.sv
// Bench: behavioural reference with integer compares, checked every clock.
module trap_cond_unit_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] insn_word = '0;
    logic [63:0] opnd_a = '0;
    logic [63:0] opnd_b = '0;
    logic        narrow_mode = 1'b0;
    logic [7:0]  exc_pending = '0;
    logic [4:0]  cmp_flags;
    logic        trap_fire;
    int          total = 0;
    int          bad = 0;
    bit          done = 1'b0;

    always #4 clk = ~clk;  // 125 MHz

    trap_cond_unit u_dut (
        .insn_word   (insn_word),
        .opnd_a      (opnd_a),
        .opnd_b      (opnd_b),
        .narrow_mode (narrow_mode),
        .exc_pending (exc_pending),
        .cmp_flags   (cmp_flags),
        .trap_fire   (trap_fire)
    );

    function automatic logic [4:0] ref_flags(logic [63:0] a, logic [63:0] b, logic nm);
        longint          sa, sb;
        longint unsigned ua, ub;
        if (nm) begin
            sa = longint'(int'(a[31:0]));
            sb = longint'(int'(b[31:0]));
            ua = {32'h0, a[31:0]};
            ub = {32'h0, b[31:0]};
        end else begin
            sa = longint'(a);
            sb = longint'(b);
            ua = a;
            ub = b;
        end
        return {sa < sb, sa > sb, ua == ub, ua < ub, ua > ub};
    endfunction

    task automatic apply(input string tag, input logic [63:0] a, input logic [63:0] b,
                         input logic nm, input logic [4:0] mask, input logic [7:0] exc,
                         input logic [31:0] other);
        logic [4:0] ef;
        logic       efire;
        @(posedge clk);
        opnd_a      = a;
        opnd_b      = b;
        narrow_mode = nm;
        exc_pending = exc;
        insn_word   = (other & ~(32'h1F << 21)) | ({27'h0, mask} << 21);
        ef    = ref_flags(a, b, nm);
        efire = (|(ef & mask)) | (|exc);
        @(negedge clk);
        total++;
        if (cmp_flags !== ef || trap_fire !== efire) begin
            bad++;
            $display("FAIL %s: flags=%b fire=%b expected flags=%b fire=%b",
                     tag, cmp_flags, trap_fire, ef, efire);
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        // Idle state: all zero inputs, equal flag only, no trap (R7)
        apply("R7 idle", 64'h0, 64'h0, 1'b0, 5'h00, 8'h0, 32'h0);
        // R4 bit order with single-bit masks
        apply("R4 ugt", 64'h5, 64'h3, 1'b0, 5'b00001, 8'h0, 32'h0);
        apply("R4 ult", 64'h3, 64'h5, 1'b0, 5'b00010, 8'h0, 32'h0);
        apply("R4 eq", 64'h7, 64'h7, 1'b0, 5'b00100, 8'h0, 32'h0);
        apply("R4 sgt", 64'h1, 64'hFFFF_FFFF_FFFF_FFFF, 1'b0, 5'b01000, 8'h0, 32'h0);
        apply("R4 slt", 64'hFFFF_FFFF_FFFF_FFFF, 64'h1, 1'b0, 5'b10000, 8'h0, 32'h0);
        apply("R5 mask miss", 64'h5, 64'h3, 1'b0, 5'b10110, 8'h0, 32'h0);
        // R1 narrow signed: upper half differs, low half sign matters
        apply("R1 narrow signed", 64'h0000_0000_8000_0000, 64'h7FFF_FFFF_0000_0001, 1'b1, 5'b10000, 8'h0, 32'h0);
        apply("R1 narrow sgt", 64'hFFFF_FFFF_0000_0002, 64'h0000_0000_FFFF_FFFF, 1'b1, 5'b01000, 8'h0, 32'h0);
        // R2 narrow unsigned/equality ignores upper half
        apply("R2 narrow eq", 64'h1234_5678_DEAD_BEEF, 64'h8765_4321_DEAD_BEEF, 1'b1, 5'b00100, 8'h0, 32'h0);
        apply("R2 narrow ugt", 64'h0000_0000_8000_0000, 64'hFFFF_FFFF_0000_0001, 1'b1, 5'b00001, 8'h0, 32'h0);
        // R3 wide mode sees the upper half
        apply("R3 wide ne", 64'h1234_5678_DEAD_BEEF, 64'h8765_4321_DEAD_BEEF, 1'b0, 5'b00100, 8'h0, 32'h0);
        apply("R3 wide signed", 64'h0000_0000_8000_0000, 64'h7FFF_FFFF_0000_0001, 1'b0, 5'b10000, 8'h0, 32'h0);
        // R6 exception override, with and without a compare hit
        apply("R6 exc only", 64'h1, 64'h2, 1'b0, 5'h00, 8'h80, 32'h0);
        apply("R6 exc and hit", 64'h1, 64'h2, 1'b0, 5'b00010, 8'h01, 32'h0);
        // R8 full mask on several pairs
        apply("R8 full eq", 64'h9, 64'h9, 1'b1, 5'h1F, 8'h0, 32'h0);
        apply("R8 full ne", 64'hF0, 64'h0F, 1'b0, 5'h1F, 8'h0, 32'h0);
        // R10 other instruction bits set, zero mask
        apply("R10 other bits", 64'h5, 64'h3, 1'b0, 5'h00, 8'h0, 32'hFC1F_FFFF);
        apply("R10 other bits hit", 64'h3, 64'h5, 1'b1, 5'b00010, 8'h0, 32'hFC1F_FFFF);
        // R9 and general: pseudo-random sweep
        for (int i = 0; i < 400; i++) begin
            logic [63:0] ra, rb;
            ra = {$urandom, $urandom};
            rb = (i % 4 == 0) ? ra : {$urandom, $urandom};
            if (i % 8 == 1) rb = {rb[63:32], ra[31:0]};
            apply("R9 sweep", ra, rb, 1'($urandom), 5'($urandom),
                  (i % 5 == 0) ? 8'($urandom) : 8'h0, $urandom);
        end
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        for (int c = 0; c < 100000; c++) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=expired expected=complete");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule